// File: doc/BRIEF.md
# Test status record writer

This block watches one run of a host loopback test and, when the run is over, writes a single 512-bit status line to the host. A start pulse clears every statistic and arms an idle watchdog. While the run is in progress, the block counts clock cycles, read requests issued, write requests issued and compare-and-exchange successes.

A run ends in one of four ways: normal completion, forced completion, a reported error, or watchdog expiry. On the cycle the run ends, the block takes a snapshot of its statistics together with the error word, the error dump and the two overhead values. In the following cycle it presents one line-write request. The request carries the status base address plus 0x40 and the packed record. A 15-bit sequence number in the record changes with every line written, so the host can tell a fresh record from a stale one.

The watchdog counts consecutive run cycles in which no read is sent, no write is sent and no response comes back. When that count reaches a programmable 32-bit limit, the run ends and the timeout bit of the error word is set.

Top module: `stat_rec_writer`

## Requirements
- R1: After reset, `rec_valid` is low, and it stays low until a run ends.
- R2: A `run_start` pulse clears all statistics and the idle count, and the run begins at the next cycle. A second `run_start` during a run restarts it, and nothing counted before the restart appears in the record.
- R3: The clock field, record bits [127:64], equals the number of run cycles after the start cycle, up to and including the cycle in which the run ends.
- R4: The read field [159:128] and the write field [191:160] count the cycles in which `rd_issued` or `wr_issued` is high during the run, including the ending cycle. Strobes that arrive outside a run are not counted.
- R5: The 16-bit compare-and-exchange field [31:16] counts the cycles in which `cas_ok` is high during the run.
- R6: When `run_done` is high during a run, `rec_valid` pulses high for exactly one cycle, one cycle later. `rec_addr` equals `stat_base` + 0x40, and record bit 0, the completion flag, is 1. `rec_data` holds its value until the next record.
- R7: `run_force` ends a run in the same way and produces the same record contents as `run_done`.
- R8: If `err_valid` is high during a run, the run ends. `err_code` is placed in the error field [63:32] and `err_dump` in [511:256]. When the run ends without an error, both fields are zero, apart from the timeout bit.
- R9: The idle count rises on each run cycle in which `rd_issued`, `wr_issued` and `rsp_seen` are all low. The run ends on the cycle in which the count reaches a non-zero `idle_limit`, and error-field bit 31 (record bit 63) is set. An `idle_limit` of 0 disables the watchdog.
- R10: Any read, write or response strobe in a run cycle resets the idle count to zero, so the full limit of idle cycles must elapse again after it.
- R11: The sequence field [15:1] is 0 in the first record after reset. It rises by one with each record and wraps from 0x7FFF to 0.
- R12: `run_done`, `run_force` and `err_valid` have no effect while no run is active: no record is produced.
- R13: The start-overhead field [223:192] and end-overhead field [255:224] take the values of `ovh_start` and `ovh_end` in the ending cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_start | input | 1 | Start (or restart) a run |
| run_done | input | 1 | Normal completion |
| run_force | input | 1 | Forced completion |
| err_valid | input | 1 | Error detected, ends the run |
| err_code | input | 32 | Error word captured with `err_valid` |
| err_dump | input | 256 | Error dump captured with `err_valid` |
| rd_issued | input | 1 | A read request was sent this cycle |
| wr_issued | input | 1 | A write request was sent this cycle |
| rsp_seen | input | 1 | A response was received this cycle |
| cas_ok | input | 1 | A compare-and-exchange succeeded this cycle |
| ovh_start | input | 32 | Start overhead value to record |
| ovh_end | input | 32 | End overhead value to record |
| idle_limit | input | 32 | Idle cycles allowed before timeout, 0 = off |
| stat_base | input | 64 | Status area base byte address |
| rec_valid | output | 1 | One-cycle line-write request |
| rec_addr | output | 64 | Byte address of the status line |
| rec_data | output | 512 | Packed status record |

## Verification
The bench places strobes on the ending cycle itself. A design that snapshots its counters one cycle early would lose those strobes and report counts that are one short. It drives the watchdog to exactly its limit and checks that no record appears one cycle sooner. It also sends a lone response in the middle of an idle stretch, to catch a watchdog that ignores responses or fails to restart its count. Restart, strobes and end events outside a run, and forced completion each test whether stale counts leak into the record or a spurious line is written. Finally, more than 32k short runs push the sequence number across 0x7FFF, which exposes a wrong width or a counter that saturates.

// File: rtl/stat_rec_pkg.sv
package stat_rec_pkg;
  localparam int REC_W   = 512;
  localparam int ID_W    = 15;
  localparam int CAS_W   = 16;
  localparam int ERR_W   = 32;
  localparam int CLK_W   = 64;
  localparam int CNT_W   = 32;
  localparam int OVH_W   = 32;
  localparam int DUMP_W  = 256;
  localparam int TMO_BIT = 31;
  localparam int NUM_EVT = 2;   // read and write strobes

  // status line, most significant field first
  typedef struct packed {
    logic [DUMP_W-1:0] dump;
    logic [OVH_W-1:0]  ovh_end;
    logic [OVH_W-1:0]  ovh_start;
    logic [CNT_W-1:0]  n_wr;
    logic [CNT_W-1:0]  n_rd;
    logic [CLK_W-1:0]  n_clk;
    logic [ERR_W-1:0]  err;
    logic [CAS_W-1:0]  cas;
    logic [ID_W-1:0]   seq;
    logic              done;
  } stat_rec_t;
endpackage

// File: rtl/stat_evt_counter.sv
module stat_evt_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] count_next
);
  localparam logic [W-1:0] ONE = 1;

  logic [W-1:0] count_q;

  always_comb begin
    count_next = count_q;
    if (clr)     count_next = '0;
    else if (en) count_next = count_q + ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= count_next;
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!clr && !en) |=> $stable(count_q)); // R4
endmodule

// File: rtl/stat_idle_watchdog.sv
module stat_idle_watchdog #(
  parameter int LIM_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             active,
  input  logic             activity,
  input  logic [LIM_W-1:0] limit,
  output logic             expired
);
  localparam logic [LIM_W-1:0] ONE = 1;

  logic [LIM_W-1:0] idle_cnt;

  always_comb
    expired = active && !activity && (limit != '0) && ((idle_cnt + ONE) == limit);

  always_ff @(posedge clk) begin
    if (rst || arm)   idle_cnt <= '0;
    else if (active)  idle_cnt <= activity ? '0 : idle_cnt + ONE;
  end

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (active && !arm && activity) |=> (idle_cnt == '0)); // R10
  AST_IDLE_BOUND: assert property (@(posedge clk) disable iff (rst)
    (active && limit != '0) |-> (idle_cnt < limit)); // R9
endmodule

// File: rtl/stat_rec_packer.sv
module stat_rec_packer
  import stat_rec_pkg::*;
#(
  parameter int                ADDR_W  = 64,
  parameter logic [ADDR_W-1:0] REC_OFS = 'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              emit,
  input  stat_rec_t         body,
  input  logic [ADDR_W-1:0] base,
  output logic              rec_valid,
  output logic [ADDR_W-1:0] rec_addr,
  output logic [REC_W-1:0]  rec_data
);
  localparam logic [ID_W-1:0] ID_ONE = 1;

  logic [ID_W-1:0] seq_id;
  stat_rec_t       line_c;

  always_comb begin
    line_c      = body;
    line_c.seq  = seq_id;
    line_c.done = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_valid <= 1'b0;
      rec_addr  <= '0;
      rec_data  <= '0;
      seq_id    <= '0;
    end else begin
      rec_valid <= emit;
      if (emit) begin
        rec_data <= line_c;
        rec_addr <= base + REC_OFS;
        seq_id   <= seq_id + ID_ONE;
      end
    end
  end

  // checker state: sequence number of the previous line
  logic            seen_q;
  logic [ID_W-1:0] last_id_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q    <= 1'b0;
      last_id_q <= '0;
    end else if (rec_valid) begin
      seen_q    <= 1'b1;
      last_id_q <= rec_data[ID_W:1];
    end
  end

  AST_ID_STEP: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && seen_q) |-> (rec_data[ID_W:1] == last_id_q + ID_ONE)); // R11
  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !emit |=> $stable(rec_data)); // R6
endmodule

// File: rtl/stat_rec_writer.sv
module stat_rec_writer
  import stat_rec_pkg::*;
#(
  parameter int                ADDR_W  = 64,
  parameter logic [ADDR_W-1:0] REC_OFS = 'h40,
  parameter int                LIM_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_start,
  input  logic              run_done,
  input  logic              run_force,
  input  logic              err_valid,
  input  logic [ERR_W-1:0]  err_code,
  input  logic [DUMP_W-1:0] err_dump,
  input  logic              rd_issued,
  input  logic              wr_issued,
  input  logic              rsp_seen,
  input  logic              cas_ok,
  input  logic [OVH_W-1:0]  ovh_start,
  input  logic [OVH_W-1:0]  ovh_end,
  input  logic [LIM_W-1:0]  idle_limit,
  input  logic [ADDR_W-1:0] stat_base,
  output logic              rec_valid,
  output logic [ADDR_W-1:0] rec_addr,
  output logic [REC_W-1:0]  rec_data
);
  logic running;
  logic counting;
  logic tmo_hit;
  logic end_evt;

  // a start in the same cycle as an end event wins: the run restarts
  assign counting = running && !run_start;
  assign end_evt  = counting && (run_done || run_force || err_valid || tmo_hit);

  always_ff @(posedge clk) begin
    if (rst)            running <= 1'b0;
    else if (run_start) running <= 1'b1;
    else if (end_evt)   running <= 1'b0;
  end

  // per-strobe counters, values that include the current cycle
  logic [NUM_EVT-1:0] evt_in;
  logic [CNT_W-1:0]   evt_next [NUM_EVT];
  assign evt_in = {wr_issued, rd_issued};

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    stat_evt_counter #(.W(CNT_W)) u_evt (
      .clk        (clk),
      .rst        (rst),
      .clr        (run_start),
      .en         (counting && evt_in[g]),
      .count_next (evt_next[g])
    );
  end

  logic [CAS_W-1:0] cas_next;
  stat_evt_counter #(.W(CAS_W)) u_cas (
    .clk        (clk),
    .rst        (rst),
    .clr        (run_start),
    .en         (counting && cas_ok),
    .count_next (cas_next)
  );

  logic [CLK_W-1:0] clk_next;
  stat_evt_counter #(.W(CLK_W)) u_clk (
    .clk        (clk),
    .rst        (rst),
    .clr        (run_start),
    .en         (counting),
    .count_next (clk_next)
  );

  stat_idle_watchdog #(.LIM_W(LIM_W)) u_wdog (
    .clk      (clk),
    .rst      (rst),
    .arm      (run_start),
    .active   (counting),
    .activity (rd_issued || wr_issued || rsp_seen),
    .limit    (idle_limit),
    .expired  (tmo_hit)
  );

  stat_rec_t        body;
  logic [ERR_W-1:0] err_word;

  always_comb begin
    err_word          = err_valid ? err_code : '0;
    err_word[TMO_BIT] = err_word[TMO_BIT] | tmo_hit;
    body              = '0;
    body.dump         = err_valid ? err_dump : '0;
    body.ovh_end      = ovh_end;
    body.ovh_start    = ovh_start;
    body.n_wr         = evt_next[1];
    body.n_rd         = evt_next[0];
    body.n_clk        = clk_next;
    body.err          = err_word;
    body.cas          = cas_next;
  end

  stat_rec_packer #(.ADDR_W(ADDR_W), .REC_OFS(REC_OFS)) u_pack (
    .clk       (clk),
    .rst       (rst),
    .emit      (end_evt),
    .body      (body),
    .base      (stat_base),
    .rec_valid (rec_valid),
    .rec_addr  (rec_addr),
    .rec_data  (rec_data)
  );

  AST_REC_PULSE: assert property (@(posedge clk) disable iff (rst)
    rec_valid |=> !rec_valid); // R6
  AST_REC_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> (!running && $past(running))); // R12
  AST_START_RUNS: assert property (@(posedge clk) disable iff (rst)
    run_start |=> running); // R2
endmodule

// File: tb/test_stat_rec_writer.sv
`timescale 1ns/1ps
module test_stat_rec_writer;
  logic         clk = 1'b0;
  logic         rst;
  logic         run_start, run_done, run_force, err_valid;
  logic [31:0]  err_code;
  logic [255:0] err_dump;
  logic         rd_issued, wr_issued, rsp_seen, cas_ok;
  logic [31:0]  ovh_start, ovh_end, idle_limit;
  logic [63:0]  stat_base;
  logic         rec_valid;
  logic [63:0]  rec_addr;
  logic [511:0] rec_data;

  always #2 clk = ~clk;

  stat_rec_writer i_stat_rec_writer (
    .clk(clk), .rst(rst), .run_start(run_start), .run_done(run_done),
    .run_force(run_force), .err_valid(err_valid), .err_code(err_code),
    .err_dump(err_dump), .rd_issued(rd_issued), .wr_issued(wr_issued),
    .rsp_seen(rsp_seen), .cas_ok(cas_ok), .ovh_start(ovh_start),
    .ovh_end(ovh_end), .idle_limit(idle_limit), .stat_base(stat_base),
    .rec_valid(rec_valid), .rec_addr(rec_addr), .rec_data(rec_data)
  );

  int checks = 0;
  int errors = 0;
  logic [14:0] exp_id = '0;

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic chk(input string req, input logic [511:0] got, input logic [511:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clr_in();
    run_start = 0; run_done = 0; run_force = 0; err_valid = 0;
    rd_issued = 0; wr_issued = 0; rsp_seen = 0; cas_ok = 0;
    err_code = '0; err_dump = '0;
  endtask

  task automatic start_run();
    run_start = 1; tick(); run_start = 0;
  endtask

  function automatic logic [511:0] exp_line(logic [14:0] id, logic [63:0] ck,
      logic [31:0] rd, logic [31:0] wr, logic [15:0] cas, logic [31:0] er,
      logic [255:0] dump, logic [31:0] os, logic [31:0] oe);
    return {dump, oe, os, wr, rd, ck, er, cas, id, 1'b1};
  endfunction

  // called at the negedge following the ending edge
  task automatic expect_rec(input string req, input logic [63:0] ck,
      input logic [31:0] rd, input logic [31:0] wr, input logic [15:0] cas,
      input logic [31:0] er, input logic [255:0] dump);
    chk({req, " rec_valid"}, 512'(rec_valid), 512'(1'b1));
    chk({req, " R6 address"}, 512'(rec_addr), 512'(stat_base + 64'h40));
    chk({req, " line"}, rec_data,
        exp_line(exp_id, ck, rd, wr, cas, er, dump, ovh_start, ovh_end));
    exp_id++;
    tick();
    chk({req, " R6 single pulse"}, 512'(rec_valid), 512'(1'b0));
  endtask

  task automatic t_reset();
    rst = 1; clr_in();
    idle_limit = 0; ovh_start = 0; ovh_end = 0; stat_base = 64'h0000_0012_3456_7000;
    repeat (3) tick();
    rst = 0;
    chk("R1 idle after reset", 512'(rec_valid), 512'(1'b0));
    repeat (5) tick();
    chk("R1 still idle", 512'(rec_valid), 512'(1'b0));
  endtask

  task automatic t_basic();
    ovh_start = 32'h0000_0111; ovh_end = 32'h0000_0222;
    start_run();
    for (int i = 1; i <= 10; i++) begin
      rd_issued = (i % 2 == 0);
      wr_issued = (i % 3 == 0);
      cas_ok    = (i == 4 || i == 10);
      run_done  = (i == 10);
      tick();
    end
    clr_in();
    // R3 clk 10, R4 rd 5 wr 3, R5 cas 2, R13 overheads
    expect_rec("R3 R4 R5 R13 basic", 64'd10, 32'd5, 32'd3, 16'd2, 32'd0, '0);
  endtask

  task automatic t_force();
    for (int k = 0; k < 2; k++) begin
      ovh_start = 32'h55; ovh_end = 32'h66;
      start_run();
      for (int i = 1; i <= 6; i++) begin
        rd_issued = 1;
        run_done  = (k == 0) && (i == 6);
        run_force = (k == 1) && (i == 6);
        tick();
      end
      clr_in();
      expect_rec(k == 0 ? "R7 done ref" : "R7 forced", 64'd6, 32'd6, 32'd0, 16'd0, 32'd0, '0);
    end
  endtask

  task automatic t_error();
    logic [255:0] dmp;
    dmp = {8{32'hC0DE_0F0F}};
    start_run();
    for (int i = 1; i <= 4; i++) begin
      rd_issued = 1;
      err_valid = (i == 4);
      err_code  = (i == 4) ? 32'h0000_0A5C : '0;
      err_dump  = (i == 4) ? dmp : '0;
      tick();
    end
    clr_in();
    expect_rec("R8 error", 64'd4, 32'd4, 32'd0, 16'd0, 32'h0000_0A5C, dmp);
  endtask

  task automatic t_ignore();
    for (int i = 0; i < 4; i++) begin
      run_done = (i == 0); run_force = (i == 1); err_valid = (i == 2);
      rd_issued = 1; wr_issued = 1; cas_ok = 1;
      tick();
      chk("R12 no line outside run", 512'(rec_valid), 512'(1'b0));
    end
    clr_in();
    start_run();
    tick();
    run_done = 1; tick(); clr_in();
    expect_rec("R4 strobes outside run", 64'd2, 32'd0, 32'd0, 16'd0, 32'd0, '0);
  endtask

  task automatic t_restart();
    start_run();
    for (int i = 1; i <= 4; i++) begin
      rd_issued = 1; cas_ok = 1; tick();
    end
    run_start = 1; rd_issued = 1; tick(); clr_in();
    chk("R2 no line on restart", 512'(rec_valid), 512'(1'b0));
    for (int i = 1; i <= 3; i++) begin
      wr_issued = 1; run_done = (i == 3); tick();
    end
    clr_in();
    expect_rec("R2 restart", 64'd3, 32'd0, 32'd3, 16'd0, 32'd0, '0);
  endtask

  task automatic t_timeout();
    idle_limit = 5;
    start_run();
    for (int i = 1; i <= 4; i++) begin
      tick();
      chk("R9 no early timeout", 512'(rec_valid), 512'(1'b0));
    end
    tick();
    expect_rec("R9 timeout", 64'd5, 32'd0, 32'd0, 16'd0, 32'h8000_0000, '0);
  endtask

  task automatic t_activity();
    idle_limit = 4;
    start_run();
    for (int i = 1; i <= 6; i++) begin
      rsp_seen = (i == 3);
      tick();
      chk("R10 response restarts idle count", 512'(rec_valid), 512'(1'b0));
    end
    clr_in();
    tick();
    expect_rec("R10 late timeout", 64'd7, 32'd0, 32'd0, 16'd0, 32'h8000_0000, '0);
  endtask

  task automatic t_nolimit();
    idle_limit = 0;
    start_run();
    for (int i = 1; i <= 40; i++) begin
      tick();
      if (i == 40) chk("R9 limit 0 disables", 512'(rec_valid), 512'(1'b0));
    end
    run_done = 1; tick(); clr_in();
    expect_rec("R9 long idle run", 64'd41, 32'd0, 32'd0, 16'd0, 32'd0, '0);
  endtask

  task automatic t_wrap();
    while (exp_id != 15'h7FFF) begin
      start_run();
      run_done = 1; tick(); run_done = 0;
      exp_id++;
    end
    start_run(); run_done = 1; tick(); run_done = 0;
    expect_rec("R11 id max", 64'd1, 32'd0, 32'd0, 16'd0, 32'd0, '0);
    chk("R11 wrapped to 0", 512'(exp_id), 512'(15'd0));
    start_run(); run_done = 1; tick(); run_done = 0;
    expect_rec("R11 id after wrap", 64'd1, 32'd0, 32'd0, 16'd0, 32'd0, '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst = 1; clr_in();
    t_reset();
    t_basic();
    t_force();
    t_error();
    t_ignore();
    t_restart();
    t_timeout();
    t_activity();
    t_nolimit();
    t_wrap();
    summary();
    $finish;
  end
endmodule